// File: doc/BRIEF.md
# Sliding Search Window Buffer

This block holds the reference-frame search window for a full-search motion estimator and moves it one block to the right at a time without a reload stall. A strip of current blocks begins with a complete window load, fed one luminance sample per cycle. While the estimator searches the current block, a second stream prefetches the N columns that the next horizontally adjacent block will need. When the estimator moves on to that block, the prefetched columns take the place of the N leftmost (oldest) window columns.

The store is a ring of SWW+N physical columns. The N spare columns act as the prefetch area. A block change only moves a base-column pointer by N, so the swap copies no data. The read side returns one row segment or one column segment of N samples per request, one cycle after the request, to the reference register shifter. A block change requested before the prefetch is complete is held until the last prefetched sample has arrived. A read issued in the same cycle as the swap already sees the new window.

Top module: `sliding_window_buf`

## Requirements
- R1: After reset, win_ready, pf_full, swap_wait, blk_done and rd_valid are all 0.
- R2: A strip_start pulse empties the window. Each of the next SWW*SWH accepted ld_valid samples is stored in column-major order: sample k goes to logical column k/SWH, row k%SWH. win_ready rises in the cycle after the last sample is stored. Load samples that arrive while win_ready is 1 are ignored.
- R3: rd_en while win_ready is 1 gives rd_valid=1 in the next cycle. Lane i of rd_data is bits 8i+7..8i. In column mode (rd_dir=0), lane i holds sample (rd_col, (rd_row+i) mod SWH). In row mode (rd_dir=1), lane i holds sample ((rd_col+i) mod SWW, rd_row). rd_en while win_ready is 0 gives rd_valid=0.
- R4: A prefetch sample is accepted only while win_ready is 1 and pf_full is 0. N*SWH samples fill the N new columns in column-major order. pf_full rises in the cycle after the last sample is accepted. Further samples are ignored until the next swap.
- R5: blk_adv while pf_full is 1 swaps in that same cycle. Logical column c then holds the former column c+N for c < SWW-N, and prefetched column c-(SWW-N) for the rest. blk_done pulses for one cycle and pf_full falls, both in the next cycle.
- R6: blk_adv while pf_full is 0 sets swap_wait in the next cycle. swap_wait stays set until the swap, which happens in the first cycle in which pf_full is 1. swap_wait falls and blk_done pulses in the cycle after that.
- R7: A read requested in the cycle of a swap returns data from the window after the swap.
- R8: Prefetch traffic does not change any sample returned for the current window before the swap.
- R9: blk_adv and pf_valid have no effect while win_ready is 0.
- R10: strip_start also drops a pending swap and discards a partial prefetch. After the reload, a prefetch needs all N*SWH samples again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strip_start | input | 1 | Start of a block strip; begins a full window load |
| ld_valid | input | 1 | Full-load sample valid |
| ld_data | input | DW | Full-load sample |
| win_ready | output | 1 | Window is complete and readable |
| pf_valid | input | 1 | Prefetch sample valid |
| pf_data | input | DW | Prefetch sample |
| pf_full | output | 1 | All N new columns are prefetched |
| blk_adv | input | 1 | Request to move to the next current block |
| swap_wait | output | 1 | A block change is waiting for the prefetch |
| blk_done | output | 1 | A swap took place in the previous cycle |
| rd_en | input | 1 | Read request |
| rd_dir | input | 1 | 0 = column segment, 1 = row segment |
| rd_col | input | clog2(SWW) | Logical start column |
| rd_row | input | clog2(SWH) | Logical start row |
| rd_valid | output | 1 | rd_data holds the result of the previous request |
| rd_data | output | N*DW | N samples, lane 0 in the low bits |

## Verification
A wrong base pointer or prefetch target shows up as wrong samples on rd_data. Lane positions tie each bad sample to a column and row, and this appears on the very first read after the faulty swap. A miscounted load or prefetch counter shows as win_ready or pf_full changing one cycle off the expected one. A lost or stuck pending swap shows in swap_wait and blk_done at the cycle the prefetch completes. A read in the swap cycle that uses the old base returns the pre-swap columns in that cycle's rd_data.

// File: rtl/sswb_pkg.sv
package sswb_pkg;

  typedef enum logic {
    DIR_COL = 1'b0,
    DIR_ROW = 1'b1
  } sswb_dir_e;

  // modular add for a, b both below m
  function automatic int unsigned wrap_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? (s - m) : s;
  endfunction

endpackage

// File: rtl/sswb_store.sv
module sswb_store #(
  parameter int DEPTH = 1280,
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int LANES = 8
) (
  input  logic                       clk,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [LANES-1:0][AW-1:0]   rd_addr_i,
  output logic [LANES-1:0][DW-1:0]   rd_data_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data_o[g] = mem_q[rd_addr_i[g]];
  end

endmodule

// File: rtl/sswb_ctrl.sv
module sswb_ctrl
  import sswb_pkg::*;
#(
  parameter int SWW = 32,
  parameter int SWH = 32,
  parameter int N   = 8,
  parameter int DW  = 8,
  localparam int P  = SWW + N,
  localparam int CW = $clog2(P),
  localparam int LW = $clog2(SWW),
  localparam int RW = $clog2(SWH),
  localparam int PW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strip_start_i,
  input  logic          ld_valid_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          pf_valid_i,
  input  logic [DW-1:0] pf_data_i,
  input  logic          blk_adv_i,
  output logic          win_ready_o,
  output logic          pf_full_o,
  output logic          swap_wait_o,
  output logic          blk_done_o,
  output logic [CW-1:0] rd_base_o,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_col_o,
  output logic [RW-1:0] wr_row_o,
  output logic [DW-1:0] wr_data_o
);

  logic          ready_q, ready_n;
  logic [LW-1:0] ld_col_q, ld_col_n;
  logic [RW-1:0] ld_row_q, ld_row_n;
  logic [PW-1:0] pf_col_q, pf_col_n;
  logic [RW-1:0] pf_row_q, pf_row_n;
  logic [CW-1:0] base_q, base_n;
  logic          wait_q, wait_n;
  logic          done_q, done_n;

  logic pf_full, ld_acc, pf_acc, swap_req, swap, ld_row_last, ld_last, pf_row_last;

  assign pf_full     = (pf_col_q == PW'(N));
  assign ld_acc      = ld_valid_i && !ready_q && !strip_start_i;
  assign pf_acc      = pf_valid_i && ready_q && !pf_full && !strip_start_i;
  assign swap_req    = ready_q && (blk_adv_i || wait_q) && !strip_start_i;
  assign swap        = swap_req && pf_full;
  assign ld_row_last = (ld_row_q == RW'(SWH - 1));
  assign ld_last     = ld_row_last && (ld_col_q == LW'(SWW - 1));
  assign pf_row_last = (pf_row_q == RW'(SWH - 1));

  // next-state logic
  always_comb begin
    ready_n  = ready_q;
    ld_col_n = ld_col_q;
    ld_row_n = ld_row_q;
    pf_col_n = pf_col_q;
    pf_row_n = pf_row_q;
    base_n   = base_q;
    wait_n   = wait_q;
    done_n   = 1'b0;
    if (strip_start_i) begin
      ready_n  = 1'b0;
      ld_col_n = '0;
      ld_row_n = '0;
      pf_col_n = '0;
      pf_row_n = '0;
      base_n   = '0;
      wait_n   = 1'b0;
    end else begin
      done_n = swap;
      wait_n = swap_req && !pf_full;
      if (ld_acc) begin
        if (ld_last) begin
          ld_col_n = '0;
          ld_row_n = '0;
          ready_n  = 1'b1;
        end else if (ld_row_last) begin
          ld_row_n = '0;
          ld_col_n = ld_col_q + LW'(1);
        end else begin
          ld_row_n = ld_row_q + RW'(1);
        end
      end
      if (swap) begin
        base_n   = CW'(wrap_add(32'(base_q), 32'(N), 32'(P)));
        pf_col_n = '0;
        pf_row_n = '0;
      end else if (pf_acc) begin
        if (pf_row_last) begin
          pf_row_n = '0;
          pf_col_n = pf_col_q + PW'(1);
        end else begin
          pf_row_n = pf_row_q + RW'(1);
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      ld_col_q <= '0;
      ld_row_q <= '0;
      pf_col_q <= '0;
      pf_row_q <= '0;
      base_q   <= '0;
      wait_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ready_q  <= ready_n;
      ld_col_q <= ld_col_n;
      ld_row_q <= ld_row_n;
      pf_col_q <= pf_col_n;
      pf_row_q <= pf_row_n;
      base_q   <= base_n;
      wait_q   <= wait_n;
      done_q   <= done_n;
    end
  end

  // reads in the swap cycle already use the advanced base
  assign rd_base_o = swap ? base_n : base_q;

  // write port: full load goes to base 0, prefetch to the spare ring columns
  assign wr_en_o   = ld_acc || pf_acc;
  assign wr_col_o  = ld_acc ? CW'(ld_col_q)
                            : CW'(wrap_add(32'(base_q), 32'(SWW) + 32'(pf_col_q), 32'(P)));
  assign wr_row_o  = ld_acc ? ld_row_q : pf_row_q;
  assign wr_data_o = ld_acc ? ld_data_i : pf_data_i;

  assign win_ready_o = ready_q;
  assign pf_full_o   = pf_full;
  assign swap_wait_o = wait_q;
  assign blk_done_o  = done_q;

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !strip_start_i |=> ready_q); // R2
  AST_PF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_full && !swap && !strip_start_i |=> pf_full); // R4
  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    base_q < CW'(P)); // R5
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && pf_full && !strip_start_i |=> !wait_q && done_q); // R6
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_q) && !$past(strip_start_i) |-> done_q); // R6
  AST_IDLE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |=> !done_q && !wait_q); // R9

endmodule

// File: rtl/sswb_rdport.sv
module sswb_rdport
  import sswb_pkg::*;
#(
  parameter int SWW = 32,
  parameter int SWH = 32,
  parameter int N   = 8,
  parameter int DW  = 8,
  localparam int P  = SWW + N,
  localparam int CW = $clog2(P),
  localparam int LW = $clog2(SWW),
  localparam int RW = $clog2(SWH),
  localparam int AW = $clog2(P * SWH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en_i,
  input  sswb_dir_e              rd_dir_i,
  input  logic [LW-1:0]          rd_col_i,
  input  logic [RW-1:0]          rd_row_i,
  input  logic                   win_ready_i,
  input  logic [CW-1:0]          base_i,
  input  logic [N-1:0][DW-1:0]   mem_data_i,
  output logic [N-1:0][AW-1:0]   mem_addr_o,
  output logic                   rd_valid_o,
  output logic [N*DW-1:0]        rd_data_o
);

  logic              fire;
  logic              valid_q, valid_n;
  logic [N*DW-1:0]   data_q, data_n;

  assign fire = rd_en_i && win_ready_i;

  for (genvar g = 0; g < N; g++) begin : g_addr
    int unsigned lcol, lrow, pcol;
    always_comb begin
      lcol = (rd_dir_i == DIR_ROW) ? wrap_add(32'(rd_col_i), 32'(g), 32'(SWW)) : 32'(rd_col_i);
      lrow = (rd_dir_i == DIR_COL) ? wrap_add(32'(rd_row_i), 32'(g), 32'(SWH)) : 32'(rd_row_i);
      pcol = wrap_add(32'(base_i), lcol, 32'(P));
      mem_addr_o[g] = AW'(pcol * 32'(SWH) + lrow);
    end
  end

  always_comb begin
    valid_n = fire;
    data_n  = data_q;
    if (fire) begin
      data_n = mem_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_n;
      data_q  <= data_n;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  AST_RD_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && win_ready_i |=> rd_valid_o); // R3
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && win_ready_i) |=> !rd_valid_o && $stable(rd_data_o)); // R3

endmodule

// File: rtl/sliding_window_buf.sv
module sliding_window_buf
  import sswb_pkg::*;
#(
  parameter int SWW = 32,
  parameter int SWH = 32,
  parameter int N   = 8,
  parameter int DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strip_start,
  input  logic                     ld_valid,
  input  logic [DW-1:0]            ld_data,
  output logic                     win_ready,
  input  logic                     pf_valid,
  input  logic [DW-1:0]            pf_data,
  output logic                     pf_full,
  input  logic                     blk_adv,
  output logic                     swap_wait,
  output logic                     blk_done,
  input  logic                     rd_en,
  input  logic                     rd_dir,
  input  logic [$clog2(SWW)-1:0]   rd_col,
  input  logic [$clog2(SWH)-1:0]   rd_row,
  output logic                     rd_valid,
  output logic [N*DW-1:0]          rd_data
);

  localparam int P     = SWW + N;
  localparam int CW    = $clog2(P);
  localparam int RW    = $clog2(SWH);
  localparam int DEPTH = P * SWH;
  localparam int AW    = $clog2(DEPTH);

  logic [CW-1:0]         rd_base;
  logic                  wr_en;
  logic [CW-1:0]         wr_col;
  logic [RW-1:0]         wr_row;
  logic [DW-1:0]         wr_data;
  logic [AW-1:0]         wr_addr;
  logic [N-1:0][AW-1:0]  mem_addr;
  logic [N-1:0][DW-1:0]  mem_data;
  sswb_dir_e             dir;

  assign dir     = sswb_dir_e'(rd_dir);
  assign wr_addr = AW'(32'(wr_col) * 32'(SWH) + 32'(wr_row));

  sswb_ctrl #(.SWW(SWW), .SWH(SWH), .N(N), .DW(DW)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .strip_start_i (strip_start),
    .ld_valid_i    (ld_valid),
    .ld_data_i     (ld_data),
    .pf_valid_i    (pf_valid),
    .pf_data_i     (pf_data),
    .blk_adv_i     (blk_adv),
    .win_ready_o   (win_ready),
    .pf_full_o     (pf_full),
    .swap_wait_o   (swap_wait),
    .blk_done_o    (blk_done),
    .rd_base_o     (rd_base),
    .wr_en_o       (wr_en),
    .wr_col_o      (wr_col),
    .wr_row_o      (wr_row),
    .wr_data_o     (wr_data)
  );

  sswb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LANES(N)) i_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (mem_addr),
    .rd_data_o (mem_data)
  );

  sswb_rdport #(.SWW(SWW), .SWH(SWH), .N(N), .DW(DW)) i_rdport (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (rd_en),
    .rd_dir_i    (dir),
    .rd_col_i    (rd_col),
    .rd_row_i    (rd_row),
    .win_ready_i (win_ready),
    .base_i      (rd_base),
    .mem_data_i  (mem_data),
    .mem_addr_o  (mem_addr),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data)
  );

endmodule

// File: tb/test_sliding_window_buf.sv
`timescale 1ns/1ps
module test_sliding_window_buf;

  localparam int SWW = 32;
  localparam int SWH = 32;
  localparam int N   = 8;
  localparam int DW  = 8;
  localparam int PFT = N * SWH;

  logic clk = 1'b0;
  logic rst_n;
  logic strip_start, ld_valid, pf_valid, blk_adv, rd_en, rd_dir;
  logic [DW-1:0] ld_data, pf_data;
  logic [$clog2(SWW)-1:0] rd_col;
  logic [$clog2(SWH)-1:0] rd_row;
  logic win_ready, pf_full, swap_wait, blk_done, rd_valid;
  logic [N*DW-1:0] rd_data;

  always #2 clk = ~clk;

  sliding_window_buf #(.SWW(SWW), .SWH(SWH), .N(N), .DW(DW)) i_sliding_window_buf (
    .clk(clk), .rst_n(rst_n), .strip_start(strip_start),
    .ld_valid(ld_valid), .ld_data(ld_data), .win_ready(win_ready),
    .pf_valid(pf_valid), .pf_data(pf_data), .pf_full(pf_full),
    .blk_adv(blk_adv), .swap_wait(swap_wait), .blk_done(blk_done),
    .rd_en(rd_en), .rd_dir(rd_dir), .rd_col(rd_col), .rd_row(rd_row),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  string ph = "R1";
  int unsigned lcg = 32'h1234_5678;

  // behavioural reference model
  int win [SWW][SWH];
  int pfb [N][SWH];
  bit m_ready, m_wait, m_done, m_valid;
  int m_ldc, m_pfc;
  logic [N*DW-1:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 0; m_wait = 0; m_done = 0; m_valid = 0;
      m_ldc = 0; m_pfc = 0; m_data = '0;
    end else begin
      bit rdy, pff, acc_ld, acc_pf, req, sw;
      rdy    = m_ready;
      pff    = (m_pfc == PFT);
      acc_ld = ld_valid && !rdy && !strip_start;
      acc_pf = pf_valid && rdy && !pff && !strip_start;
      req    = rdy && (blk_adv || m_wait) && !strip_start;
      sw     = req && pff;
      if (sw) begin
        for (int c = 0; c < SWW; c++)
          for (int r = 0; r < SWH; r++)
            win[c][r] = (c < SWW - N) ? win[c + N][r] : pfb[c - (SWW - N)][r];
      end
      m_valid = rd_en && rdy;
      if (m_valid) begin
        for (int i = 0; i < N; i++) begin
          if (rd_dir == 1'b0) m_data[i*DW +: DW] = DW'(win[rd_col][(int'(rd_row) + i) % SWH]);
          else                m_data[i*DW +: DW] = DW'(win[(int'(rd_col) + i) % SWW][rd_row]);
        end
      end
      if (strip_start) begin
        m_ready = 0; m_ldc = 0; m_pfc = 0; m_wait = 0; m_done = 0;
      end else begin
        m_done = sw;
        m_wait = req && !pff;
        if (acc_ld) begin
          win[m_ldc / SWH][m_ldc % SWH] = int'(ld_data);
          m_ldc++;
          if (m_ldc == SWW * SWH) begin m_ready = 1; m_ldc = 0; end
        end
        if (sw) m_pfc = 0;
        else if (acc_pf) begin
          pfb[m_pfc / SWH][m_pfc % SWH] = int'(pf_data);
          m_pfc++;
        end
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [N*DW-1:0] act,
                     input logic [N*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s: actual %h expected %h at %0t", rq, ph, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk("R2", "win_ready", {63'd0, win_ready}, {63'd0, m_ready});
      chk("R4", "pf_full",   {63'd0, pf_full},   {63'd0, (m_pfc == PFT)});
      chk("R6", "swap_wait", {63'd0, swap_wait}, {63'd0, m_wait});
      chk("R5", "blk_done",  {63'd0, blk_done},  {63'd0, m_done});
      chk("R3", "rd_valid",  {63'd0, rd_valid},  {63'd0, m_valid});
      if (m_valid) chk("R3", "rd_data", rd_data, m_data);
    end
  end

  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  task automatic idle();
    strip_start = 0; ld_valid = 0; pf_valid = 0; blk_adv = 0; rd_en = 0;
  endtask

  task automatic rand_read(input bit en);
    rd_en  = en;
    rd_dir = nxt() % 2;
    rd_col = $bits(rd_col)'(nxt());
    rd_row = $bits(rd_row)'(nxt());
  endtask

  task automatic load_window(input int seed);
    @(negedge clk); idle(); strip_start = 1;
    for (int k = 0; k < SWW * SWH; k++) begin
      @(negedge clk); idle();
      if (k % 37 == 5) begin rand_read(1); @(negedge clk); idle(); end
      ld_valid = 1; ld_data = DW'(k * 7 + seed);
    end
    for (int j = 0; j < 3; j++) begin   // extra samples must be ignored
      @(negedge clk); idle(); ld_valid = 1; ld_data = 8'hEE;
    end
    @(negedge clk); idle();
  endtask

  task automatic reads(input int n);
    for (int j = 0; j < n; j++) begin @(negedge clk); idle(); rand_read(1); end
    @(negedge clk); idle();
  endtask

  task automatic prefetch(input int seed, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk); idle(); rand_read(1);
      if (k % 29 == 3) begin @(negedge clk); idle(); end
      pf_valid = 1; pf_data = DW'(k * 11 + seed * 5 + 3);
    end
    @(negedge clk); idle();
  endtask

  initial begin
    rst_n = 0; idle(); rd_dir = 0; rd_col = '0; rd_row = '0; ld_data = '0; pf_data = '0;
    repeat (4) @(negedge clk);
    chk("R1", "win_ready", {63'd0, win_ready}, 64'd0);
    chk("R1", "pf_full",   {63'd0, pf_full},   64'd0);
    chk("R1", "swap_wait", {63'd0, swap_wait}, 64'd0);
    chk("R1", "blk_done",  {63'd0, blk_done},  64'd0);
    chk("R1", "rd_valid",  {63'd0, rd_valid},  64'd0);
    rst_n = 1;

    ph = "R9";
    @(negedge clk); idle(); blk_adv = 1;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); idle(); pf_valid = 1; pf_data = 8'h5A; rand_read(1);
    end
    @(negedge clk); idle();

    ph = "R2";  load_window(3);
    ph = "R3";  reads(200);
    ph = "R8";  prefetch(0, PFT + 4);
    reads(40);

    ph = "R7";
    @(negedge clk); idle(); blk_adv = 1; rand_read(1);
    ph = "R5";  reads(80);

    for (int b = 1; b <= 6; b++) begin
      ph = "R6";
      @(negedge clk); idle(); blk_adv = 1;
      repeat (3) begin @(negedge clk); idle(); end
      prefetch(b, PFT);
      repeat (2) begin @(negedge clk); idle(); end
      reads(40);
    end

    ph = "R10";
    @(negedge clk); idle(); blk_adv = 1;
    prefetch(9, 100);
    load_window(77);
    prefetch(10, PFT);
    @(negedge clk); idle(); blk_adv = 1; rand_read(1);
    reads(60);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog (phase %s): actual timeout expected completion", ph);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule